// File: doc/BRIEF.md
# Six-Step Commutation PWM Predriver

This block produces the six gate commands for a three-phase half-bridge running a brushless motor in 120-degree rectangular drive. All commands are active high, with one high-side and one low-side command per leg. The block takes a decoded 3-bit rotor position and a direction bit, and in each commutation step it gives every leg one of three roles. The chopped leg is switched by a PWM carrier. The sink leg keeps its low-side switch on. The floating leg has both gates off. The chopped leg switches in a complementary way: its high side is on during the active part of the carrier and its low side is on during the rest, with a programmable dead time inserted between the two.

The duty word is digital. It is saturated at a fixed ceiling of about 95 %. The carrier period is 2^DUTY_W clocks. An elaboration check rejects a parameter set whose carrier would fall below 17 kHz, or whose bootstrap precharge time would fall outside 0.333 to 0.5 ms, for the stated clock rate. When the run enable rises, all three low sides are switched on for a fixed number of cycles so that the high-side bootstrap capacitors charge before commutation begins. A free-run request floats the bridge. A current-limit flag clamps the motor by grounding the chopped and sink legs.

Top module: `bldc_sixstep_drv`

## Requirements
- R1: With dirRev=0, the chopped/sink leg pairs (leg 0=U, 1=V, 2=W) for rotorPos codes 1,3,2,6,4,5 are (U,V), (U,W), (V,W), (V,U), (W,U), (W,V). The third leg floats with both gates low.
- R2: With dirRev=1, the chopped and sink roles of each code are swapped. The floating leg is unchanged.
- R3: rotorPos codes 0 and 7 turn all six outputs off.
- R4: The carrier period is 2^DUTY_W clocks. For an effective duty D>0, the chopped leg's high command is on for D-dt cycles per period and its low command for 2^DUTY_W-D-dt cycles, where dt is the selected dead time. With D=0 the chopped leg behaves as a sink leg.
- R5: Duty words above DUTY_MAX (default 243 of 256) act as DUTY_MAX.
- R6: deadSel 0, 1, 2 and 3 select DT_SHORT, DT_MID, DT_LONG and DT_LONG. A gate of a leg turns on only after both gates of that leg have been off for at least the selected number of cycles.
- R7: The high and low commands of one leg are never on in the same cycle.
- R8: A rising edge on runEn (with freeRun low) turns on all three low commands, and keeps all high commands off, for exactly PRECHG_CYC cycles before normal drive begins.
- R9: While runEn is low, all outputs are off. A falling edge on runEn causes no precharge and cuts short a precharge in progress.
- R10: freeRun turns all outputs off, overriding precharge and drive.
- R11: With curLimit high and a valid position, the chopped and sink legs hold their low commands on and the floating leg stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rotorPos | input | 3 | Decoded rotor position code |
| dirRev | input | 1 | Reverse rotation request |
| duty | input | DUTY_W | Requested PWM duty |
| deadSel | input | 2 | Dead-time selection |
| curLimit | input | 1 | Current-limit clamp request |
| runEn | input | 1 | Run enable; its rising edge starts precharge |
| freeRun | input | 1 | Float all phases |
| gateHi | output | 3 | High-side commands, bit 0 = U |
| gateLo | output | 3 | Low-side commands, bit 0 = U |

## Verification
Each leg's high-side and low-side on-cycles are counted over full carrier periods. Those counts are compared with the arithmetic on-times. A sweep over duty and dead-time select separates saturation, zero duty and each dead-time value from the others. A second sweep covers all eight position codes in both directions. Because a wrong role lands as a wrong count on a specific leg, this sweep tells the table, the direction swap and the invalid codes apart. Current limit, free run and run-enable edges are each applied from a steady running state. The all-low interval after a rising run edge is counted to the exact cycle, including a precharge that is cut short and one that is restarted.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_LOW = 2'd1,
    LEG_PWM = 2'd2
  } legCmd_t;

  typedef struct packed {
    logic       valid;
    logic [1:0] chopLeg;
    logic [1:0] sinkLeg;
  } stepMap_t;

  // Strobes from control to datapath: one command per leg.
  typedef struct packed {
    legCmd_t [2:0] leg;
  } driveStrobe_t;

  // Forward-direction role map; legs 0=U, 1=V, 2=W.
  function automatic stepMap_t decodeStep(input logic [2:0] pos);
    stepMap_t m;
    m = '{valid: 1'b1, chopLeg: 2'd0, sinkLeg: 2'd1};
    case (pos)
      3'd1: begin m.chopLeg = 2'd0; m.sinkLeg = 2'd1; end
      3'd3: begin m.chopLeg = 2'd0; m.sinkLeg = 2'd2; end
      3'd2: begin m.chopLeg = 2'd1; m.sinkLeg = 2'd2; end
      3'd6: begin m.chopLeg = 2'd1; m.sinkLeg = 2'd0; end
      3'd4: begin m.chopLeg = 2'd2; m.sinkLeg = 2'd0; end
      3'd5: begin m.chopLeg = 2'd2; m.sinkLeg = 2'd1; end
      default: m.valid = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sixstep_leg.sv
module sixstep_leg
  import sixstep_pkg::*;
#(
  parameter int DTW    = 5,
  parameter int DT_SAT = 24
) (
  input  logic           clk,
  input  logic           rstN,
  input  legCmd_t        cmd,
  input  logic           pwmOn,
  input  logic [DTW-1:0] deadCyc,
  output logic           gateHi,
  output logic           gateLo
);

  localparam logic [DTW-1:0] GAP_TOP = DTW'(DT_SAT);

  logic           wantHi, wantLo, hiNext, loNext;
  logic [DTW-1:0] offGap;

  always_comb begin
    wantHi = (cmd == LEG_PWM) && pwmOn;
    wantLo = (cmd == LEG_LOW) || ((cmd == LEG_PWM) && !pwmOn);
    hiNext = wantHi && !gateLo && (gateHi || (offGap >= deadCyc));
    loNext = wantLo && !gateHi && (gateLo || (offGap >= deadCyc));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateHi <= 1'b0;
      gateLo <= 1'b0;
      offGap <= GAP_TOP;
    end else begin
      gateHi <= hiNext;
      gateLo <= loNext;
      if (hiNext || loNext)     offGap <= '0;
      else if (offGap != GAP_TOP) offGap <= offGap + 1'b1;
    end
  end

endmodule

// File: rtl/sixstep_dp.sv
module sixstep_dp
  import sixstep_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int DUTY_MAX = 243,
  parameter int DTW      = 5,
  parameter int DT_SAT   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  driveStrobe_t      strobe,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DTW-1:0]    deadCyc,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo
);

  localparam logic [DUTY_W-1:0] DUTY_CAP = DUTY_W'(DUTY_MAX);

  logic [DUTY_W-1:0] carrier;
  logic [DUTY_W-1:0] dutyEff;
  logic              pwmOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carrier <= '0;
    else       carrier <= carrier + 1'b1;
  end

  always_comb begin
    dutyEff = (duty > DUTY_CAP) ? DUTY_CAP : duty;
    pwmOn   = carrier < dutyEff;
  end

  for (genvar g = 0; g < 3; g++) begin : g_leg
    sixstep_leg #(.DTW(DTW), .DT_SAT(DT_SAT)) u_leg (
      .clk     (clk),
      .rstN    (rstN),
      .cmd     (strobe.leg[g]),
      .pwmOn   (pwmOn),
      .deadCyc (deadCyc),
      .gateHi  (gateHi[g]),
      .gateLo  (gateLo[g])
    );
  end

endmodule

// File: rtl/sixstep_ctrl.sv
module sixstep_ctrl
  import sixstep_pkg::*;
#(
  parameter int PRECHG_CYC = 100000,
  parameter int DT_SHORT   = 6,
  parameter int DT_MID     = 12,
  parameter int DT_LONG    = 24,
  parameter int DTW        = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     rotorPos,
  input  logic           dirRev,
  input  logic [1:0]     deadSel,
  input  logic           curLimit,
  input  logic           runEn,
  input  logic           freeRun,
  output driveStrobe_t   strobe,
  output logic [DTW-1:0] deadCyc
);

  localparam int PCW = $clog2(PRECHG_CYC + 1);

  logic           runQ;
  logic [PCW-1:0] pcCnt;
  logic           runRise, pcActive;
  stepMap_t       step;
  logic [1:0]     chopLeg, sinkLeg;

  assign runRise  = runEn && !runQ;
  assign pcActive = runRise || (pcCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      pcCnt <= '0;
    end else begin
      runQ <= runEn;
      if (!runEn)          pcCnt <= '0;
      else if (runRise)    pcCnt <= PCW'(PRECHG_CYC - 1);
      else if (pcCnt != 0) pcCnt <= pcCnt - 1'b1;
    end
  end

  always_comb begin
    case (deadSel)
      2'd0:    deadCyc = DTW'(DT_SHORT);
      2'd1:    deadCyc = DTW'(DT_MID);
      default: deadCyc = DTW'(DT_LONG);
    endcase
  end

  always_comb begin
    step    = decodeStep(rotorPos);
    chopLeg = dirRev ? step.sinkLeg : step.chopLeg;
    sinkLeg = dirRev ? step.chopLeg : step.sinkLeg;
    for (int i = 0; i < 3; i++) begin
      if (!runEn || freeRun)       strobe.leg[i] = LEG_OFF;
      else if (pcActive)           strobe.leg[i] = LEG_LOW;
      else if (!step.valid)        strobe.leg[i] = LEG_OFF;
      else if (2'(i) == chopLeg)   strobe.leg[i] = curLimit ? LEG_LOW : LEG_PWM;
      else if (2'(i) == sinkLeg)   strobe.leg[i] = LEG_LOW;
      else                         strobe.leg[i] = LEG_OFF;
    end
  end

endmodule

// File: rtl/bldc_sixstep_drv.sv
module bldc_sixstep_drv
  import sixstep_pkg::*;
#(
  parameter int CLK_KHZ    = 250000,
  parameter int DUTY_W     = 8,
  parameter int DUTY_MAX   = 243,
  parameter int PRECHG_CYC = 100000,
  parameter int DT_SHORT   = 6,
  parameter int DT_MID     = 12,
  parameter int DT_LONG    = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        rotorPos,
  input  logic              dirRev,
  input  logic [DUTY_W-1:0] duty,
  input  logic [1:0]        deadSel,
  input  logic              curLimit,
  input  logic              runEn,
  input  logic              freeRun,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo
);

  localparam int DT_SM  = (DT_SHORT > DT_MID) ? DT_SHORT : DT_MID;
  localparam int DT_SAT = (DT_SM > DT_LONG) ? DT_SM : DT_LONG;
  localparam int DTW    = $clog2(DT_SAT + 1);

  if (CLK_KHZ < 17 * (2 ** DUTY_W)) begin : g_slowCarrier
    $error("carrier below 17 kHz for this clock");
  end
  if ((3 * PRECHG_CYC < CLK_KHZ) || (2 * PRECHG_CYC > CLK_KHZ)) begin : g_badPrechg
    $error("precharge outside 0.333..0.5 ms");
  end

  driveStrobe_t   strobe;
  logic [DTW-1:0] deadCyc;

  sixstep_ctrl #(
    .PRECHG_CYC(PRECHG_CYC), .DT_SHORT(DT_SHORT), .DT_MID(DT_MID),
    .DT_LONG(DT_LONG), .DTW(DTW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rotorPos(rotorPos), .dirRev(dirRev),
    .deadSel(deadSel), .curLimit(curLimit), .runEn(runEn),
    .freeRun(freeRun), .strobe(strobe), .deadCyc(deadCyc)
  );

  sixstep_dp #(
    .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX), .DTW(DTW), .DT_SAT(DT_SAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .duty(duty),
    .deadCyc(deadCyc), .gateHi(gateHi), .gateLo(gateLo)
  );

endmodule

// File: rtl/sixstep_chk.sv
module sixstep_chk #(
  parameter int PRECHG_CYC = 100000,
  parameter int DT_SHORT   = 6,
  parameter int DT_MID     = 12,
  parameter int DT_LONG    = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] rotorPos,
  input logic [1:0] deadSel,
  input logic       runEn,
  input logic       freeRun,
  input logic [2:0] gateHi,
  input logic [2:0] gateLo
);

  localparam int DT_SM  = (DT_SHORT > DT_MID) ? DT_SHORT : DT_MID;
  localparam int DT_SAT = (DT_SM > DT_LONG) ? DT_SM : DT_LONG;

  function automatic int deadOf(input logic [1:0] sel);
    return (sel == 2'd0) ? DT_SHORT : (sel == 2'd1) ? DT_MID : DT_LONG;
  endfunction

  int  offRun [3];
  int  allLowRun;
  logic badPos;

  assign badPos = (rotorPos == 3'd0) || (rotorPos == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) offRun[i] <= DT_SAT;
      allLowRun <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (gateHi[i] || gateLo[i])  offRun[i] <= 0;
        else if (offRun[i] < DT_SAT) offRun[i] <= offRun[i] + 1;
      end
      if ((&gateLo) && (gateHi == 3'b000)) allLowRun <= allLowRun + 1;
      else                                 allLowRun <= 0;
    end
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == 3'b000);

  for (genvar g = 0; g < 3; g++) begin : g_dead
    // R6
    hi_dead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[g]) |-> offRun[g] >= deadOf($past(deadSel)));
    // R6
    lo_dead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[g]) |-> offRun[g] >= deadOf($past(deadSel)));
  end

  // R10
  free_run_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeRun && $past(freeRun) |-> (gateHi == 3'b000) && (gateLo == 3'b000));

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && $past(!runEn) |-> (gateHi == 3'b000) && (gateLo == 3'b000));

  // R3
  bad_pos_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    badPos && $past(badPos) |-> (gateHi == 3'b000) &&
                                ((gateLo == 3'b000) || (gateLo == 3'b111)));

  // R8
  prechg_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    allLowRun <= PRECHG_CYC);

endmodule

bind bldc_sixstep_drv sixstep_chk #(
  .PRECHG_CYC(PRECHG_CYC), .DT_SHORT(DT_SHORT), .DT_MID(DT_MID), .DT_LONG(DT_LONG)
) u_chk (
  .clk(clk), .rstN(rstN), .rotorPos(rotorPos), .deadSel(deadSel),
  .runEn(runEn), .freeRun(freeRun), .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/sim_bldc_sixstep_drv.sv
`timescale 1ns/1ps
module sim_bldc_sixstep_drv;

  localparam int PRE  = 3200;
  localparam int DTS  = 3;
  localparam int DTM  = 5;
  localparam int DTL  = 9;
  localparam int CAP  = 243;
  localparam int PER  = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rotorPos = 3'd1;
  logic       dirRev = 1'b0;
  logic [7:0] duty = 8'd128;
  logic [1:0] deadSel = 2'd0;
  logic       curLimit = 1'b0;
  logic       runEn = 1'b0;
  logic       freeRun = 1'b0;
  logic [2:0] gateHi, gateLo;

  int nChk = 0;
  int nFail = 0;
  int hiCnt [3];
  int loCnt [3];
  int overlapCnt = 0;
  int allLowCnt;

  always #2 clk = ~clk;

  bldc_sixstep_drv #(
    .CLK_KHZ(8192), .DUTY_W(8), .DUTY_MAX(CAP), .PRECHG_CYC(PRE),
    .DT_SHORT(DTS), .DT_MID(DTM), .DT_LONG(DTL)
  ) u0 (
    .clk(clk), .rstN(rstN), .rotorPos(rotorPos), .dirRev(dirRev),
    .duty(duty), .deadSel(deadSel), .curLimit(curLimit), .runEn(runEn),
    .freeRun(freeRun), .gateHi(gateHi), .gateLo(gateLo)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(input int n);
    for (int i = 0; i < 3; i++) begin hiCnt[i] = 0; loCnt[i] = 0; end
    allLowCnt = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        hiCnt[i] += int'(gateHi[i]);
        loCnt[i] += int'(gateLo[i]);
      end
      if ((gateHi & gateLo) != 3'b000) overlapCnt++;
      if (gateLo == 3'b111 && gateHi == 3'b000) allLowCnt++;
    end
  endtask

  function automatic int deadOf(input int sel);
    return (sel == 0) ? DTS : (sel == 1) ? DTM : DTL;
  endfunction

  // role: 0 float, 1 sink, 2 chopped
  function automatic int roleOf(input int leg, input int code, input bit rev);
    int c, s;
    case (code)
      1: begin c = 0; s = 1; end
      3: begin c = 0; s = 2; end
      2: begin c = 1; s = 2; end
      6: begin c = 1; s = 0; end
      4: begin c = 2; s = 0; end
      5: begin c = 2; s = 1; end
      default: return 0;
    endcase
    if (rev) begin int t = c; c = s; s = t; end
    if (leg == c) return 2;
    if (leg == s) return 1;
    return 0;
  endfunction

  task automatic checkLeg(input string req, input int leg, input int role,
                          input int d, input int dt);
    int eh, el;
    if (role == 0)               begin eh = 0;     el = 0; end
    else if (role == 1 || d == 0) begin eh = 0;     el = PER; end
    else                         begin eh = d - dt; el = PER - d - dt; end
    check(hiCnt[leg] == eh, $sformatf("%s leg%0d high count", req, leg), hiCnt[leg], eh);
    check(loCnt[leg] == el, $sformatf("%s leg%0d low count", req, leg), loCnt[leg], el);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int dutyList [8] = '{0, 10, 50, 128, 200, 243, 250, 255};
    settle(5);
    check(gateHi == 3'b000 && gateLo == 3'b000, "R9 reset state", {gateHi, gateLo}, 0);
    rstN = 1'b1;
    settle(40);
    check(gateHi == 3'b000 && gateLo == 3'b000, "R9 idle outputs off", {gateHi, gateLo}, 0);

    // R8: precharge length on run start
    runEn = 1'b1;
    window(PRE + 200);
    check(allLowCnt == PRE, "R8 precharge cycles", allLowCnt, PRE);

    // R4 R5 R6: duty and dead-time sweep, code 1 forward
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        int d;
        deadSel = 2'(s);
        duty = 8'(dutyList[k]);
        d = (dutyList[k] > CAP) ? CAP : dutyList[k];
        settle(300);
        window(PER);
        checkLeg((dutyList[k] > CAP) ? "R5 R6" : "R4 R6", 0, 2, d, deadOf(s));
        checkLeg("R1", 1, 1, d, deadOf(s));
        checkLeg("R1", 2, 0, d, deadOf(s));
      end
    end

    // R1 R2 R3: all codes, both directions
    duty = 8'd128;
    deadSel = 2'd0;
    for (int r = 0; r < 2; r++) begin
      for (int code = 0; code < 8; code++) begin
        rotorPos = 3'(code);
        dirRev = r[0];
        settle(300);
        window(PER);
        for (int leg = 0; leg < 3; leg++)
          checkLeg((code == 0 || code == 7) ? "R3" : (r == 1 ? "R2" : "R1"),
                   leg, roleOf(leg, code, r[0]), 128, DTS);
      end
    end

    // R11: current limit clamps chopped and sink legs low
    dirRev = 1'b0;
    curLimit = 1'b1;
    for (int code = 1; code < 7; code++) begin
      rotorPos = 3'(code);
      settle(300);
      window(PER);
      for (int leg = 0; leg < 3; leg++)
        checkLeg("R11", leg, (roleOf(leg, code, 1'b0) == 0) ? 0 : 1, 128, DTS);
    end
    curLimit = 1'b0;
    rotorPos = 3'd1;
    settle(300);

    // R10: free run floats everything
    freeRun = 1'b1;
    settle(3);
    window(PER);
    for (int leg = 0; leg < 3; leg++) checkLeg("R10", leg, 0, 128, DTS);
    freeRun = 1'b0;
    settle(300);

    // R9: falling run enable, no precharge
    runEn = 1'b0;
    settle(3);
    window(PER);
    for (int leg = 0; leg < 3; leg++) checkLeg("R9", leg, 0, 128, DTS);
    check(allLowCnt == 0, "R9 no precharge on fall", allLowCnt, 0);

    // R8: precharge again on new rise
    runEn = 1'b1;
    window(PRE + 200);
    check(allLowCnt == PRE, "R8 second precharge cycles", allLowCnt, PRE);

    // R9: abort mid-precharge
    runEn = 1'b0;
    settle(40);
    runEn = 1'b1;
    settle(1000);
    check(gateLo == 3'b111 && gateHi == 3'b000, "R8 precharge in progress",
          {gateHi, gateLo}, 7);
    runEn = 1'b0;
    settle(3);
    window(PER);
    for (int leg = 0; leg < 3; leg++) checkLeg("R9 abort", leg, 0, 128, DTS);

    // R10: free run held across a run start
    freeRun = 1'b1;
    runEn = 1'b1;
    settle(1);
    window(PER);
    for (int leg = 0; leg < 3; leg++) checkLeg("R10 over precharge", leg, 0, 128, DTS);
    freeRun = 1'b0;
    settle(PRE);

    check(overlapCnt == 0, "R7 overlap cycles", overlapCnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule